// File: doc/BRIEF.md
# Transceiver Mode and Transmit Sequencer

This block sits between a host controller and an SPI register master that talks to a 2.4 GHz radio transceiver. It owns the transceiver's chip-enable line. It turns one high-level operation into the exact series of SPI transactions and chip-enable edges the radio needs. The operations are: enter receive role, enter transmit role, power up, power down, and send one payload of 1 to 32 bytes taken from a byte stream.

Every operation starts with the same clean-up run. Chip-enable goes low, both radio FIFOs are flushed, and the interrupt flags are cleared. The block then reads the radio's configuration byte and rewrites only the bit that the operation concerns. For a role change the write is left out when the radio already has the requested role. A send goes on to flush the transmit FIFO, burst the payload, and pulse chip-enable. Each chip-enable change is followed by a settle interval of `WAIT_CYC` clock cycles. The block accepts one operation at a time and pulses `done` when it finishes.

The SPI master handshake is as follows. `spi_req` stays high with a stable command byte and data count until `spi_done`. The master pulses `spi_wtake` as it consumes each data byte from `spi_wdata`. It presents the last byte shifted in on `spi_rbyte` in the `spi_done` cycle.

Top module: `xcvr_mode_seq`

## Requirements
- R1: After reset `ce`, `busy`, `done`, `spi_req` and `pay_pop` are all low.
- R2: Every accepted operation begins with chip-enable low, then these transactions in order: flush receive FIFO (command 0xE2, one data byte 0x00), flush transmit FIFO (0xE1, 0x00), status write (0x27, data 0x70), and configuration read (0x00, one dummy 0x00 byte).
- R3: Operation code 0 (receive role): if configuration bit 0 is 0, the block writes command 0x20 with the read value OR 0x01 and then drives `ce` high. If bit 0 is already 1, there is no write and `ce` stays low.
- R4: Operation code 1 (transmit role): if bit 0 is 1, the block writes 0x20 with bit 0 cleared. Otherwise there is no write. `ce` stays low in both cases.
- R5: Operation codes 2 and 3 (power up/down) always write 0x20 with bit 1 set (code 2) or cleared (code 3). All other bits keep their read values.
- R6: Operation code 4 (send) runs the transmit-role sequence, then flush transmit (0xE1, 0x00), then command 0xA0 with `op_len` data bytes taken from the stream in order. It then drives `ce` high for exactly `WAIT_CYC` cycles and low again. `pay_pop` is asserted only while those payload bytes are being consumed.
- R7: After each change of `ce`, `WAIT_CYC` cycles pass before the next SPI request or completion. In particular, the first request comes `WAIT_CYC` cycles after `busy` rises.
- R8: `busy` is high from the cycle after acceptance until completion. `done` is a single-cycle pulse, once per operation.
- R9: `op_valid` while `busy` is high is ignored.
- R10: A send with `op_len` of 0 or above 32, and an operation code above 4, are ignored: `busy` does not rise and no SPI request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation request strobe |
| op_code | input | 3 | 0 receive role, 1 transmit role, 2 power up, 3 power down, 4 send |
| op_len | input | 6 | Payload length for send (1..32) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| ce | output | 1 | Transceiver chip-enable |
| spi_req | output | 1 | SPI transaction request, held until spi_done |
| spi_cmd | output | 8 | Command byte of the transaction |
| spi_len | output | 6 | Number of data bytes after the command |
| spi_wdata | output | 8 | Current data byte to send |
| spi_wtake | input | 1 | Master consumes spi_wdata this cycle |
| spi_done | input | 1 | Transaction finished |
| spi_rbyte | input | 8 | Last byte received, valid with spi_done |
| pay_data | input | 8 | Head byte of the payload stream |
| pay_pop | output | 1 | Advance the payload stream |

## Verification
The hardest cases to reach are the ones that depend on what the radio reports, not on what the host asks. These are the skipped configuration write and the send that needs no role change. The bench's SPI master model holds its own configuration byte, returns it on reads, and updates it on writes. Each table row preloads that byte, so the same operation code is run once with the role already matching and once with it differing. Rejecting a request while busy is reached by raising a conflicting send in the middle of a receive-role sequence.

// File: rtl/xcvr_seq_pkg.sv
package xcvr_seq_pkg;

    typedef enum logic [2:0] {
        OP_RX      = 3'd0,
        OP_TX      = 3'd1,
        OP_PWR_ON  = 3'd2,
        OP_PWR_OFF = 3'd3,
        OP_SEND    = 3'd4
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CE_LO, ST_FL_RX, ST_FL_TX, ST_CLR, ST_RD, ST_DEC,
        ST_WR, ST_CE_HI, ST_FL_TX2, ST_PAY, ST_PULSE_HI, ST_PULSE_LO
    } st_e;

    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] wdata;
    } spi_op_t;

    localparam logic [7:0] CMD_WR_REG   = 8'h20;
    localparam logic [7:0] CMD_WR_PAY   = 8'hA0;
    localparam logic [7:0] CMD_FLUSH_TX = 8'hE1;
    localparam logic [7:0] CMD_FLUSH_RX = 8'hE2;
    localparam logic [7:0] ADDR_CFG     = 8'h00;
    localparam logic [7:0] ADDR_STAT    = 8'h07;
    localparam logic [7:0] IRQ_ALL      = 8'h70;
    localparam int         ROLE_BIT     = 0;
    localparam int         PWR_BIT      = 1;

    function automatic logic op_acceptable(input logic [2:0] code,
                                           input int unsigned len,
                                           input int unsigned max_len);
        if (code > 3'd4) return 1'b0;
        if (code == OP_SEND) return (len != 0) && (len <= max_len);
        return 1'b1;
    endfunction

endpackage

// File: rtl/xcvr_seq_wait.sv
module xcvr_seq_wait #(
    parameter int WAIT_CYC = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic hit
);
    localparam int CNT_W = $clog2(WAIT_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    assign hit = en && (cnt_q == CNT_W'(WAIT_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !en || hit) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(WAIT_CYC)); // R7
endmodule

// File: rtl/xcvr_seq_cfgcalc.sv
module xcvr_seq_cfgcalc
    import xcvr_seq_pkg::*;
(
    input  op_e        op,
    input  logic [7:0] cfg_rd,
    output logic       skip,
    output logic [7:0] cfg_wr
);
    always_comb begin
        skip   = 1'b0;
        cfg_wr = cfg_rd;
        unique case (op)
            OP_RX: begin
                skip             = cfg_rd[ROLE_BIT];
                cfg_wr[ROLE_BIT] = 1'b1;
            end
            OP_TX, OP_SEND: begin
                skip             = !cfg_rd[ROLE_BIT];
                cfg_wr[ROLE_BIT] = 1'b0;
            end
            OP_PWR_ON:  cfg_wr[PWR_BIT] = 1'b1;
            OP_PWR_OFF: cfg_wr[PWR_BIT] = 1'b0;
            default: ;
        endcase
    end
endmodule

// File: rtl/xcvr_mode_seq.sv
module xcvr_mode_seq
    import xcvr_seq_pkg::*;
#(
    parameter int WAIT_CYC = 500,
    parameter int MAX_PAY  = 32,
    parameter int LEN_W    = $clog2(MAX_PAY + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [2:0]       op_code,
    input  logic [LEN_W-1:0] op_len,
    output logic             busy,
    output logic             done,
    output logic             ce,
    output logic             spi_req,
    output logic [7:0]       spi_cmd,
    output logic [LEN_W-1:0] spi_len,
    output logic [7:0]       spi_wdata,
    input  logic             spi_wtake,
    input  logic             spi_done,
    input  logic [7:0]       spi_rbyte,
    input  logic [7:0]       pay_data,
    output logic             pay_pop
);
    st_e              state_q, state_d;
    op_e              op_q;
    logic [LEN_W-1:0] len_q;
    logic [7:0]       cfg_q, cfg_new;
    logic             ce_q, done_q, skip, wait_en, wait_hit;
    spi_op_t          sop;

    xcvr_seq_wait #(.WAIT_CYC(WAIT_CYC)) wait_i (
        .clk(clk), .rst(rst), .en(wait_en), .hit(wait_hit)
    );

    xcvr_seq_cfgcalc calc_i (
        .op(op_q), .cfg_rd(cfg_q), .skip(skip), .cfg_wr(cfg_new)
    );

    assign wait_en = (state_q == ST_CE_LO) || (state_q == ST_CE_HI) ||
                     (state_q == ST_PULSE_HI) || (state_q == ST_PULSE_LO);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (op_valid && op_acceptable(op_code, int'(op_len), MAX_PAY))
                    state_d = ST_CE_LO;
            ST_CE_LO:    if (wait_hit) state_d = ST_FL_RX;
            ST_FL_RX:    if (spi_done) state_d = ST_FL_TX;
            ST_FL_TX:    if (spi_done) state_d = ST_CLR;
            ST_CLR:      if (spi_done) state_d = ST_RD;
            ST_RD:       if (spi_done) state_d = ST_DEC;
            ST_DEC:
                if (!skip)                state_d = ST_WR;
                else if (op_q == OP_SEND) state_d = ST_FL_TX2;
                else                      state_d = ST_IDLE;
            ST_WR:
                if (spi_done) begin
                    if (op_q == OP_RX)        state_d = ST_CE_HI;
                    else if (op_q == OP_SEND) state_d = ST_FL_TX2;
                    else                      state_d = ST_IDLE;
                end
            ST_CE_HI:    if (wait_hit) state_d = ST_IDLE;
            ST_FL_TX2:   if (spi_done) state_d = ST_PAY;
            ST_PAY:      if (spi_done) state_d = ST_PULSE_HI;
            ST_PULSE_HI: if (wait_hit) state_d = ST_PULSE_LO;
            ST_PULSE_LO: if (wait_hit) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        sop     = '{cmd: 8'h00, wdata: 8'h00};
        spi_req = 1'b1;
        spi_len = LEN_W'(1);
        unique case (state_q)
            ST_FL_RX:  sop.cmd = CMD_FLUSH_RX;
            ST_FL_TX,
            ST_FL_TX2: sop.cmd = CMD_FLUSH_TX;
            ST_CLR:    sop = '{cmd: CMD_WR_REG | ADDR_STAT, wdata: IRQ_ALL};
            ST_RD:     sop.cmd = ADDR_CFG;
            ST_WR:     sop = '{cmd: CMD_WR_REG | ADDR_CFG, wdata: cfg_new};
            ST_PAY: begin
                sop     = '{cmd: CMD_WR_PAY, wdata: pay_data};
                spi_len = len_q;
            end
            default:   spi_req = 1'b0;
        endcase
    end

    assign spi_cmd   = sop.cmd;
    assign spi_wdata = sop.wdata;
    assign pay_pop   = (state_q == ST_PAY) && spi_wtake;
    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign ce        = ce_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_RX;
            len_q   <= '0;
            cfg_q   <= '0;
            ce_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
            if (state_q == ST_IDLE && state_d != ST_IDLE) begin
                op_q  <= op_e'(op_code);
                len_q <= op_len;
            end
            if (state_q == ST_RD && spi_done) cfg_q <= spi_rbyte;
            if (state_d != state_q) begin
                if (state_d == ST_CE_LO || state_d == ST_PULSE_LO) ce_q <= 1'b0;
                if (state_d == ST_CE_HI || state_d == ST_PULSE_HI) ce_q <= 1'b1;
            end
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !spi_req && !pay_pop); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        spi_req && !spi_done |=> spi_req && $stable(spi_cmd)); // R2
    AST_PAY_CE_LOW: assert property (@(posedge clk) disable iff (rst)
        spi_req && spi_cmd == CMD_WR_PAY |-> !ce); // R6
    AST_POP_IN_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
        pay_pop |-> spi_req && spi_cmd == CMD_WR_PAY); // R6
    AST_RX_SETS_ROLE: assert property (@(posedge clk) disable iff (rst)
        spi_req && spi_cmd == (CMD_WR_REG | ADDR_CFG) && op_q == OP_RX
        |-> spi_wdata[ROLE_BIT]); // R3
endmodule

// File: tb/xcvr_mode_seq_tb_top.sv
module xcvr_mode_seq_tb_top;
    localparam int W = 6;

    logic       clk = 1'b0, rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [2:0] op_code = '0;
    logic [5:0] op_len = '0;
    logic       busy, done, ce, spi_req, spi_wtake, spi_done, pay_pop;
    logic [7:0] spi_cmd, spi_wdata, spi_rbyte, pay_data;
    logic [5:0] spi_len;

    always #10 clk = ~clk;

    xcvr_mode_seq #(.WAIT_CYC(W)) dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_len(op_len), .busy(busy), .done(done), .ce(ce),
        .spi_req(spi_req), .spi_cmd(spi_cmd), .spi_len(spi_len),
        .spi_wdata(spi_wdata), .spi_wtake(spi_wtake), .spi_done(spi_done),
        .spi_rbyte(spi_rbyte), .pay_data(pay_data), .pay_pop(pay_pop)
    );

    int checks = 0, fails = 0, cyc = 0;

    // SPI master model with a radio configuration byte
    logic [7:0] cfg_model = 8'h08;
    logic       m_act = 1'b0, m_ph = 1'b0;
    logic [7:0] m_cmd = '0;
    int         m_len = 0, m_byte = 0;
    int         ntr = 0, npl = 0, pidx = 0;
    logic [7:0] tr_cmd [1024];
    int         tr_len [1024];
    logic [7:0] tr_d0  [1024];
    logic [7:0] pl_log [1024];

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    assign spi_wtake = m_act && !m_ph && (m_byte >= 1);
    assign spi_done  = m_act && m_ph && (m_byte == m_len);
    assign spi_rbyte = cfg_model;
    assign pay_data  = pat(pidx);

    always @(posedge clk) begin
        if (pay_pop) pidx <= pidx + 1;
        if (rst) m_act <= 1'b0;
        else if (!m_act) begin
            if (spi_req) begin
                m_act <= 1'b1; m_cmd <= spi_cmd; m_len <= int'(spi_len);
                m_byte <= 0; m_ph <= 1'b0;
                tr_cmd[ntr] <= spi_cmd; tr_len[ntr] <= int'(spi_len);
                ntr <= ntr + 1;
            end
        end else begin
            if (spi_wtake) begin
                if (m_byte == 1) tr_d0[ntr-1] <= spi_wdata;
                if (m_cmd == 8'hA0) begin pl_log[npl] <= spi_wdata; npl <= npl + 1; end
                if (m_cmd == 8'h20) cfg_model <= spi_wdata;
            end
            if (m_ph) begin
                if (m_byte == m_len) m_act <= 1'b0;
                else m_byte <= m_byte + 1;
                m_ph <= 1'b0;
            end else m_ph <= 1'b1;
        end
    end

    // monitors
    int tr_base = 0, pre_cnt = 0, ce_hi_cnt = 0, done_cnt = 0;
    logic busy_seen = 1'b0;
    always @(negedge clk) begin
        if (busy && !spi_req && ntr == tr_base) pre_cnt <= pre_cnt + 1;
        if (ce && busy) ce_hi_cnt <= ce_hi_cnt + 1;
        if (done) done_cnt <= done_cnt + 1;
        if (busy) busy_seen <= 1'b1;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start_op(input logic [2:0] code, input logic [5:0] len, input logic [7:0] cfg);
        @(posedge clk);
        pre_cnt = 0; ce_hi_cnt = 0; done_cnt = 0; busy_seen = 1'b0;
        @(negedge clk);
        cfg_model = cfg; tr_base = ntr;
        op_valid = 1'b1; op_code = code; op_len = len;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (done) break;
        end
        repeat (3) @(negedge clk);
    endtask

    // {op, len, cfg_init, cfg_exp, ntrans, ce_after}
    localparam int NV = 10;
    localparam logic [39:0] VEC [NV] = '{
        {8'd0, 8'd0,  8'h08, 8'h09, 4'd5, 4'd1},
        {8'd0, 8'd0,  8'h09, 8'h09, 4'd4, 4'd0},
        {8'd1, 8'd0,  8'h0B, 8'h0A, 4'd5, 4'd0},
        {8'd1, 8'd0,  8'h0A, 8'h0A, 4'd4, 4'd0},
        {8'd2, 8'd0,  8'h08, 8'h0A, 4'd5, 4'd0},
        {8'd2, 8'd0,  8'h0B, 8'h0B, 4'd5, 4'd0},
        {8'd3, 8'd0,  8'h7F, 8'h7D, 4'd5, 4'd0},
        {8'd4, 8'd3,  8'h0A, 8'h0A, 4'd6, 4'd0},
        {8'd4, 8'd32, 8'h0B, 8'h0A, 4'd7, 4'd0},
        {8'd4, 8'd1,  8'h03, 8'h02, 4'd7, 4'd0}
    };

    initial begin
        forever begin
            @(posedge clk); cyc++;
            if (cyc > 150000) begin
                fails++;
                $display("FAIL watchdog expired");
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!ce && !busy && !done && !spi_req && !pay_pop, "R1 reset outputs",
              {ce, busy, done, spi_req, pay_pop}, 0);

        for (int v = 0; v < NV; v++) begin
            logic [2:0] op;
            int len, n, pl0, pb;
            logic [7:0] ci, ce_exp_cfg;
            string rq;
            op = VEC[v][34:32]; len = int'(VEC[v][31:24]);
            ci = VEC[v][23:16]; ce_exp_cfg = VEC[v][15:8]; n = int'(VEC[v][7:4]);
            rq = (op == 0) ? "R3" : (op == 1) ? "R4" : (op == 4) ? "R6" : "R5";
            pl0 = npl; pb = pidx;
            start_op(op, 6'(len), ci);
            wait_done();
            check(done_cnt == 1, "R8 done pulse count", done_cnt, 1);
            check(ntr - tr_base == n, {rq, " transaction count"}, ntr - tr_base, n);
            // R2 preamble
            check(tr_cmd[tr_base] == 8'hE2 && tr_d0[tr_base] == 8'h00 &&
                  tr_cmd[tr_base+1] == 8'hE1 && tr_d0[tr_base+1] == 8'h00 &&
                  tr_cmd[tr_base+2] == 8'h27 && tr_d0[tr_base+2] == 8'h70 &&
                  tr_cmd[tr_base+3] == 8'h00 && tr_len[tr_base+3] == 1,
                  "R2 preamble order", tr_cmd[tr_base+2], 8'h27);
            check(cfg_model == ce_exp_cfg, {rq, " configuration value"}, cfg_model, ce_exp_cfg);
            check(ce == VEC[v][0], {rq, " chip-enable after"}, ce, VEC[v][0]);
            check(pre_cnt == W, "R7 settle before first request", pre_cnt, W);
            if ((op == 0 && n == 5) || op == 4)
                check(ce_hi_cnt == W, "R7 chip-enable high interval", ce_hi_cnt, W);
            else
                check(ce_hi_cnt == 0, {rq, " chip-enable stays low"}, ce_hi_cnt, 0);
            if (n >= 5 && op != 4 || n == 7)
                check(tr_cmd[tr_base+4] == 8'h20, {rq, " config write command"}, tr_cmd[tr_base+4], 8'h20);
            if (op == 4) begin
                check(tr_cmd[ntr-2] == 8'hE1 && tr_cmd[ntr-1] == 8'hA0 && tr_len[ntr-1] == len,
                      "R6 flush then payload burst", tr_len[ntr-1], len);
                check(npl - pl0 == len, "R6 payload byte count", npl - pl0, len);
                for (int k = 0; k < len; k++)
                    if (pl_log[pl0+k] != pat(pb + k))
                        check(1'b0, "R6 payload byte", pl_log[pl0+k], pat(pb + k));
                check(!ce, "R6 chip-enable low after pulse", ce, 0);
            end
        end

        // R9: request while busy is ignored
        begin
            int pl0;
            pl0 = npl;
            start_op(3'd0, 6'd0, 8'h08);
            repeat (4) @(negedge clk);
            op_valid = 1'b1; op_code = 3'd4; op_len = 6'd4;
            repeat (3) @(negedge clk);
            op_valid = 1'b0;
            wait_done();
            repeat (30) @(negedge clk);
            check(ntr - tr_base == 5, "R9 busy request ignored, transactions", ntr - tr_base, 5);
            check(npl == pl0 && !busy, "R9 no payload and idle", npl - pl0, 0);
            check(cfg_model == 8'h09 && ce, "R9 receive role completed", cfg_model, 8'h09);
        end

        // R10: invalid length and code
        begin
            logic [2:0] bc [4] = '{3'd4, 3'd4, 3'd5, 3'd7};
            logic [5:0] bl [4] = '{6'd0, 6'd33, 6'd1, 6'd1};
            for (int t = 0; t < 4; t++) begin
                start_op(bc[t], bl[t], 8'h08);
                repeat (20) @(negedge clk);
                check(!busy_seen && ntr == tr_base, "R10 invalid request ignored", ntr - tr_base, 0);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule